// File: doc/BRIEF.md
# Parallel-Chain Logic Self-Test Engine

This block runs a built-in logic self-test on a small circuit that has its flip-flops stitched into several parallel scan chains. A 16-bit pseudo-random generator drives the serial inputs of all chains at the same time. A 16-bit multiple-input signature register folds the chain outputs into one signature. A per-chain mask can block any chain whose captured data may be unknown.

After a start request, the controller loads the first stimulus. It then alternates one capture cycle with a combined unload-and-load shift phase, once for each programmed pattern. A last shift phase unloads the response of the final pattern. The resulting signature is compared with an expected value to give a single pass or fail verdict. Short parallel chains keep each shift phase only one chain length long.

The circuit under test is outside the block. The engine drives its shift and capture enables and its serial inputs, and it reads its serial outputs.

Top module: `lbist_engine`

## Requirements
- R1: While reset is held, and after it is released with no start, busy, done, pass, shift_en, capt_en and signature are all 0.
- R2: A start seen while idle has these effects on the next cycle: the generator is loaded with the seed 0xACE1, the signature is cleared, pass is cleared, pat_count and mask are latched, and busy rises. A start seen while busy has no effect.
- R3: For a latched count P, the run has P+1 shift phases of CHAIN_LEN cycles each. Shift phases are separated by single capture cycles, so there are P capture cycles. shift_en and capt_en are never high together.
- R4: The generator advances once per shift cycle as g' = {g[14:0], g[15]^g[13]^g[12]^g[10]}. It holds during capture cycles. Chain k's serial input is generator bit 4k.
- R5: On every shift cycle of phases 2 to P+1, the signature updates as s' = {s[14:0], s[15]^s[13]^s[12]^s[10]} XOR v. Here v holds the masked chain outputs in bits 0 to 3. The signature holds during the first (load-only) phase and during capture cycles.
- R6: A chain whose latched mask bit is 1 contributes a constant 0 to the signature. Unknown data on that chain therefore leaves the signature unchanged.
- R7: One finish cycle follows the final shift phase, with busy still high. On the next cycle, done is high for exactly one cycle and busy is low. At that point pass equals (signature == expected), with expected sampled in the finish cycle.
- R8: pass and signature keep their values while idle, until the next accepted start.
- R9: With P = 0, the run is a single load phase, and it finishes with signature 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a self-test run |
| pat_count | input | PCW | Number of patterns (latched at start) |
| mask | input | NCH | Per-chain block bits, 1 = excluded (latched at start) |
| expected | input | W | Expected final signature |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Final signature matched expected |
| signature | output | W | Current signature register |
| shift_en | output | 1 | Chains shift this cycle |
| capt_en | output | 1 | Chains capture this cycle |
| chain_si | output | NCH | Serial data into each chain |
| chain_so | input | NCH | Serial data out of each chain |

## Verification
The checker watches every cycle for these properties:
- shift and capture enables are never high together;
- a capture is always preceded by a shift;
- the signature holds through a capture;
- done lasts one cycle and arrives with busy low;
- pass and signature stay stable while idle.

The bench's scenarios are needed for the rest. It uses a behavioural model of the generator, the compactor and the chained circuit to check the exact generator sequence on the serial inputs and the exact signature value. The scenarios also cover the exclusion of the load phase from compaction, a start ignored mid-run, the zero-pattern run, and the way a masked chain with random captured data still gives a repeatable signature.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FIN   = 2'd3
  } lbist_state_e;
endpackage

// File: rtl/lbist_rst_sync.sv
module lbist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/lbist_lfsr.sv
module lbist_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_q;
    if (load)     q_nxt = SEED;
    else if (adv) q_nxt = {q_q[W-2:0], ^(q_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_nxt;
  end

  assign q = q_q;
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr #(
  parameter int          W    = 16,
  parameter int          NIN  = 4,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           en,
  input  logic [NIN-1:0] din,
  output logic [W-1:0]   q
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_nxt;
  logic [W-1:0] din_ext;

  assign din_ext = {{(W-NIN){1'b0}}, din};

  always_comb begin
    q_nxt = q_q;
    if (clr)     q_nxt = '0;
    else if (en) q_nxt = {q_q[W-2:0], ^(q_q & TAPS)} ^ din_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_nxt;
  end

  assign q = q_q;
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int W         = 16,
  parameter int NCH       = 4,
  parameter int CHAIN_LEN = 16,
  parameter int PCW       = 8,
  localparam int SCW      = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] pat_count,
  input  logic [NCH-1:0] mask,
  input  logic [W-1:0]   expected,
  input  logic [W-1:0]   sig,
  output logic           seed_ld,
  output logic           gen_adv,
  output logic           cmp_en,
  output logic [NCH-1:0] msk,
  output logic           busy,
  output logic           done,
  output logic           pass,
  output logic           shift_en,
  output logic           capt_en
);
  localparam logic [SCW-1:0] LAST_BIT = SCW'(CHAIN_LEN - 1);

  lbist_state_e   st_q,  st_nxt;
  logic [SCW-1:0] sh_q,  sh_nxt;
  logic [PCW-1:0] ph_q,  ph_nxt;
  logic [PCW-1:0] cnt_q, cnt_nxt;
  logic [NCH-1:0] msk_q, msk_nxt;
  logic           done_q, done_nxt;
  logic           pass_q, pass_nxt;
  logic           start_ok;

  assign start_ok = start && (st_q == ST_IDLE);

  always_comb begin
    st_nxt   = st_q;
    sh_nxt   = sh_q;
    ph_nxt   = ph_q;
    cnt_nxt  = cnt_q;
    msk_nxt  = msk_q;
    pass_nxt = pass_q;
    done_nxt = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_nxt   = ST_SHIFT;
          sh_nxt   = '0;
          ph_nxt   = '0;
          cnt_nxt  = pat_count;
          msk_nxt  = mask;
          pass_nxt = 1'b0;
        end
      end
      ST_SHIFT: begin
        if (sh_q == LAST_BIT) begin
          sh_nxt = '0;
          st_nxt = (ph_q == cnt_q) ? ST_FIN : ST_CAPT;
        end else begin
          sh_nxt = sh_q + SCW'(1);
        end
      end
      ST_CAPT: begin
        st_nxt = ST_SHIFT;
        ph_nxt = ph_q + PCW'(1);
      end
      ST_FIN: begin
        st_nxt   = ST_IDLE;
        done_nxt = 1'b1;
        pass_nxt = (sig == expected);
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      ph_q   <= '0;
      cnt_q  <= '0;
      msk_q  <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st_q   <= st_nxt;
      sh_q   <= sh_nxt;
      ph_q   <= ph_nxt;
      cnt_q  <= cnt_nxt;
      msk_q  <= msk_nxt;
      done_q <= done_nxt;
      pass_q <= pass_nxt;
    end
  end

  assign seed_ld  = start_ok;
  assign shift_en = (st_q == ST_SHIFT);
  assign capt_en  = (st_q == ST_CAPT);
  assign gen_adv  = shift_en;
  assign cmp_en   = shift_en && (ph_q != '0);
  assign msk      = msk_q;
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign pass     = pass_q;
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
  parameter int           W         = 16,
  parameter int           NCH       = 4,
  parameter int           CHAIN_LEN = 16,
  parameter int           PCW       = 8,
  parameter logic [W-1:0] TAPS      = 16'hB400,
  parameter logic [W-1:0] SEED      = 16'hACE1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PCW-1:0] pat_count,
  input  logic [NCH-1:0] mask,
  input  logic [W-1:0]   expected,
  output logic           busy,
  output logic           done,
  output logic           pass,
  output logic [W-1:0]   signature,
  output logic           shift_en,
  output logic           capt_en,
  output logic [NCH-1:0] chain_si,
  input  logic [NCH-1:0] chain_so
);
  localparam int STRIDE = W / NCH;

  logic           rst_s_n;
  logic           seed_ld;
  logic           gen_adv;
  logic           cmp_en;
  logic [NCH-1:0] msk;
  logic [NCH-1:0] cmp_in;
  logic [W-1:0]   gen_q;
  logic [W-1:0]   sig_q;

  lbist_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  lbist_ctrl #(
    .W(W), .NCH(NCH), .CHAIN_LEN(CHAIN_LEN), .PCW(PCW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .pat_count (pat_count),
    .mask      (mask),
    .expected  (expected),
    .sig       (sig_q),
    .seed_ld   (seed_ld),
    .gen_adv   (gen_adv),
    .cmp_en    (cmp_en),
    .msk       (msk),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .shift_en  (shift_en),
    .capt_en   (capt_en)
  );

  lbist_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (seed_ld),
    .adv   (gen_adv),
    .q     (gen_q)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_tap
    assign chain_si[k] = gen_q[k*STRIDE];
    assign cmp_in[k]   = chain_so[k] & ~msk[k];
  end

  lbist_misr #(.W(W), .NIN(NCH), .TAPS(TAPS)) u_sig (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (seed_ld),
    .en    (cmp_en),
    .din   (cmp_in),
    .q     (sig_q)
  );

  assign signature = sig_q;
endmodule

// File: rtl/lbist_engine_chk.sv
module lbist_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         pass,
  input logic [W-1:0] signature,
  input logic         shift_en,
  input logic         capt_en
);
  AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en && capt_en)); // R3

  AST_CAPT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    capt_en |-> $past(shift_en)); // R3

  AST_SIG_HOLD_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
    capt_en |=> $stable(signature)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!shift_en && !capt_en)); // R1

  AST_PASS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(pass)); // R8

  AST_SIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(signature)); // R8
endmodule

bind lbist_engine lbist_engine_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .pass      (pass),
  .signature (signature),
  .shift_en  (shift_en),
  .capt_en   (capt_en)
);

// File: tb/lbist_engine_tb_top.sv
`timescale 1ns/1ps
module lbist_engine_tb_top;
  localparam int W   = 16;
  localparam int NCH = 4;
  localparam int L   = 16;
  localparam int PCW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [PCW-1:0] pat_count = '0;
  logic [NCH-1:0] mask = '0;
  logic [W-1:0]   expected = '0;
  logic           busy, done, pass, shift_en, capt_en;
  logic [W-1:0]   signature;
  logic [NCH-1:0] chain_si, chain_so;

  int checks = 0;
  int failures = 0;
  bit xmode = 1'b0;

  always #5 clk = ~clk;

  lbist_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_count(pat_count),
    .mask(mask), .expected(expected), .busy(busy), .done(done),
    .pass(pass), .signature(signature), .shift_en(shift_en),
    .capt_en(capt_en), .chain_si(chain_si), .chain_so(chain_so)
  );

  // circuit under test: four chains plus a small capture function
  logic [L-1:0] ch [NCH];
  logic [L-1:0] nx [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_so
    assign chain_so[k] = ch[k][L-1];
  end

  initial for (int c = 0; c < NCH; c++) ch[c] = '0;

  always @(posedge clk) begin
    if (shift_en) begin
      for (int c = 0; c < NCH; c++) nx[c] = {ch[c][L-2:0], chain_si[c]};
    end else if (capt_en) begin
      for (int c = 0; c < NCH; c++)
        for (int i = 0; i < L; i++)
          nx[c][i] = ch[c][i] ^ (ch[(c+1)%NCH][(i+3)%L] & ~ch[(c+2)%NCH][i]) ^ ch[(c+3)%NCH][(i+1)%L];
      if (xmode) nx[NCH-1] = L'($urandom);
    end else begin
      for (int c = 0; c < NCH; c++) nx[c] = ch[c];
    end
    for (int c = 0; c < NCH; c++) ch[c] <= nx[c];
  end

  function automatic logic [15:0] step16(input logic [15:0] x);
    int fb;
    fb = ((int'(x) >> 15) ^ (int'(x) >> 13) ^ (int'(x) >> 12) ^ (int'(x) >> 10)) & 1;
    return 16'(((int'(x) << 1) | fb) & 16'hFFFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  logic [15:0] last_sig;

  // one run; model checked every cycle; poke_start pulses start mid-run
  task automatic run(input int p, input logic [3:0] m, input logic [15:0] e, input bit poke_start);
    logic [15:0] g, s;
    logic [3:0] so, si_exp;
    @(negedge clk);
    start = 1'b1; pat_count = PCW'(p); mask = m; expected = e;
    @(negedge clk);
    start = 1'b0;
    mask = ~m; pat_count = PCW'(p + 5);
    g = 16'hACE1; s = 16'h0000;
    chk(pass == 1'b0, "R2 pass cleared at start", 32'(pass), 0);
    chk(signature == 16'h0, "R2 signature cleared", 32'(signature), 0);
    for (int ph = 0; ph <= p; ph++) begin
      for (int i = 0; i < L; i++) begin
        si_exp = {g[12], g[8], g[4], g[0]};
        chk(busy && shift_en && !capt_en && !done, "R3 shift cycle", {busy, shift_en, capt_en, done}, 4'b1100);
        chk(chain_si == si_exp, "R4 serial inputs", 32'(chain_si), 32'(si_exp));
        chk(signature == s, "R5 signature during shift", 32'(signature), 32'(s));
        so = chain_so;
        if (ph > 0) s = step16(s) ^ {12'h000, so & ~m};
        g = step16(g);
        @(negedge clk);
      end
      if (ph < p) begin
        chk(busy && capt_en && !shift_en, "R3 capture cycle", {busy, shift_en, capt_en}, 3'b101);
        chk(signature == s, "R5 hold in capture", 32'(signature), 32'(s));
        if (poke_start && ph == 0) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    chk(busy && !shift_en && !capt_en && !done, "R7 finish cycle", {busy, shift_en, capt_en, done}, 4'b1000);
    chk(signature == s, "R5 final signature", 32'(signature), 32'(s));
    @(negedge clk);
    chk(done && !busy, "R7 done pulse", {done, busy}, 2'b10);
    chk(pass == (s == e), "R7 verdict", 32'(pass), 32'(s == e));
    chk(signature == s, "R7 signature at done", 32'(signature), 32'(s));
    last_sig = s;
    @(negedge clk);
    chk(!done, "R7 done one cycle", 32'(done), 0);
    repeat (3) @(negedge clk);
    chk(pass == (s == e) && signature == s, "R8 held while idle", {pass, signature}, {(s == e), s});
  endtask

  logic [15:0] sig_a;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !shift_en && !capt_en && signature == 0, "R1 during reset",
        {busy, done, pass, shift_en, capt_en}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !pass && !shift_en && !capt_en && signature == 0, "R1 after reset",
        {busy, done, pass, shift_en, capt_en}, 0);

    run(3, 4'b0000, 16'h0000, 1'b0);
    sig_a = last_sig;
    chk(sig_a != 16'h0, "R5 nonzero signature", 32'(sig_a), 1);
    run(3, 4'b0000, sig_a, 1'b0);
    chk(pass, "R5 repeatable run passes", 32'(pass), 1);
    run(3, 4'b0000, sig_a ^ 16'h0001, 1'b1);
    chk(!pass, "R2 ignored start, mismatch fails", 32'(pass), 0);

    xmode = 1'b1;
    run(4, 4'b1000, 16'h0000, 1'b0);
    sig_a = last_sig;
    run(4, 4'b1000, sig_a, 1'b0);
    chk(pass && last_sig == sig_a, "R6 masked unknown chain repeatable", 32'(last_sig), 32'(sig_a));
    run(2, 4'b1111, 16'h0000, 1'b0);
    chk(last_sig == 16'h0 && pass, "R6 all masked gives zero", 32'(last_sig), 0);
    xmode = 1'b0;

    run(0, 4'b0000, 16'h0000, 1'b0);
    chk(last_sig == 16'h0 && pass, "R9 zero patterns", 32'(last_sig), 0);
    run(1, 4'b0101, 16'h1234, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_500_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule